// File: doc/BRIEF.md
# Translation Request Coalescer

This unit sits in front of an address-translation cache and cuts the number of lookups it sees. Every incoming request brings a virtual address, an access mode, a prefetch flag, a request count and an optional arrival stamp. The stamp is divided by a fixed window length to give a bucket number. Requests whose bucket, virtual page and mode are all equal are folded into one group, and each group later goes downstream as a single probe.

Each cycle a selector offers up to `NLANE` groups on parallel probe lanes. Lower bucket numbers go first, and inside a bucket older groups go first. A group is held back while a probe for the same page is still outstanding. A small in-flight table records every issued page. A response naming that page releases the page one cycle after the response arrives. A lane is taken only when it and every lower lane are ready in that cycle. Groups that are refused stay queued and are offered again on the next cycle.

Top module: `xlat_coalescer`

## Requirements
- R1: After reset no probe lane is valid, no group is stored and `req_ready` is 1.
- R2: The effective stamp is `req_stamp` when that input is nonzero. Otherwise it is the unit's own cycle counter, which is 0 in the first cycle after reset. The bucket is the effective stamp divided by `WINDOW`.
- R3: With merging enabled, an accepted request joins the stored group that has the same bucket, the same page (`req_vaddr >> PAGE_SHIFT`) and the same mode, and the group's member count rises by one.
- R4: A request that differs from every stored group in bucket, page or mode opens a new group with a member count of 1.
- R5: A new group's count starts at the creating request's `req_count`, whether or not that request is a prefetch. A merged non-prefetch request adds its `req_count` to the group count. A merged prefetch request adds 0.
- R6: Lane 0 carries the group with the lowest bucket. Among groups with equal buckets, the group created first comes first. Later lanes continue the same order.
- R7: At most `NLANE` probes are offered per cycle. The valid lanes form a contiguous run starting at lane 0, and no two lanes offered in the same cycle carry the same page.
- R8: A group whose page is in flight is not offered. After a response for that page is sampled at clock edge E, the page is cleared at edge E+1, and the group is offered after E+1.
- R9: Lane k is taken only if `probe_ready[k]` is 1 and every lower lane is taken. A group that is not taken stays stored and is offered again on the next cycle.
- R10: While `cfg_merge_off` is 1, every accepted request opens its own group (member count 1, count equal to its `req_count`).
- R11: `req_ready` is 0 in each of these cases: (a) all `NGROUP` slots are used and no group matches the request; (b) the matching group already holds `NMEMB` members; (c) the matching group is being taken in the same cycle. Merging into a stored group is still possible when all slots are used.
- R12: At most `NIFL` pages are in flight at once. Lanes beyond the number of free in-flight entries are not offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_merge_off | input | 1 | 1 disables merging |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_vaddr | input | VA_W | Virtual address |
| req_mode | input | MODE_W | Access mode |
| req_prefetch | input | 1 | Request is a prefetch |
| req_count | input | CNT_W | Number of requests this one stands for |
| req_stamp | input | STAMP_W | First-arrival stamp; 0 means not yet stamped |
| probe_valid | output | NLANE | Per-lane probe offer |
| probe_ready | input | NLANE | Per-lane downstream acceptance |
| probe_vpn | output | NLANE*VPN_W | Per-lane virtual page |
| probe_mode | output | NLANE*MODE_W | Per-lane mode |
| probe_count | output | NLANE*ACC_W | Per-lane accumulated count |
| probe_members | output | NLANE*MEM_W | Per-lane member count |
| rsp_valid | input | 1 | Translation for `rsp_vpn` completed |
| rsp_vpn | input | VPN_W | Page of the completed translation |

## Verification
The probe lanes are computed combinationally from registered group state. A request accepted at an edge is therefore visible on the lanes in the half cycle after that edge, and every lane check is made at the following falling edge. `req_ready` also depends combinationally on the current request and on `probe_ready`, so it is checked one time step after the inputs are driven and before the next rising edge. A response releases its page two edges after it is driven. The in-flight test therefore checks the lanes at the falling edge after each of those two edges: blocked after the first, offered after the second.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int XC_VA_W       = 32;
    localparam int XC_PAGE_SHIFT = 12;
    localparam int XC_MODE_W     = 2;
    localparam int XC_CNT_W      = 8;
    localparam int XC_STAMP_W    = 16;
    localparam int XC_WINDOW     = 8;
    localparam int XC_NGROUP     = 16;
    localparam int XC_NMEMB      = 8;
    localparam int XC_NLANE      = 2;
    localparam int XC_NIFL       = 4;
endpackage

// File: rtl/xlat_merge_match.sv
module xlat_merge_match #(
    parameter int NG     = 16,
    parameter int BKT_W  = 16,
    parameter int VPN_W  = 20,
    parameter int MODE_W = 2,
    parameter int MEM_W  = 4,
    parameter int NMEMB  = 8,
    localparam int IDX_W = $clog2(NG)
) (
    input  logic                           merge_off,
    input  logic [BKT_W-1:0]               req_bkt,
    input  logic [VPN_W-1:0]               req_vpn,
    input  logic [MODE_W-1:0]              req_mode,
    input  logic [NG-1:0]                  slot_valid,
    input  logic [NG-1:0][BKT_W-1:0]       slot_bkt,
    input  logic [NG-1:0][VPN_W-1:0]       slot_vpn,
    input  logic [NG-1:0][MODE_W-1:0]      slot_mode,
    input  logic [NG-1:0][MEM_W-1:0]       slot_mem,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx,
    output logic                           full
);
    // lowest matching slot wins; uniqueness is normally kept by the store
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NG - 1; i >= 0; i--) begin
            if (!merge_off && slot_valid[i] && slot_bkt[i] == req_bkt &&
                slot_vpn[i] == req_vpn && slot_mode[i] == req_mode) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
        full = hit && (slot_mem[idx] >= MEM_W'(NMEMB));
    end
endmodule

// File: rtl/xlat_issue_sel.sv
module xlat_issue_sel #(
    parameter int NG    = 16,
    parameter int NLANE = 2,
    parameter int BKT_W = 16,
    parameter int VPN_W = 20,
    parameter int FC_W  = 3,
    localparam int IDX_W = $clog2(NG)
) (
    input  logic [NG-1:0]                 slot_valid,
    input  logic [NG-1:0][BKT_W-1:0]      slot_bkt,
    input  logic [NG-1:0][VPN_W-1:0]      slot_vpn,
    input  logic [NG-1:0][NG-1:0]         older,
    input  logic [NG-1:0]                 blocked,
    input  logic [FC_W-1:0]               free_cnt,
    output logic [NLANE-1:0]              pick_valid,
    output logic [NLANE-1:0][IDX_W-1:0]   pick_idx
);
    logic [NG-1:0]    taken;
    logic             best_ok;
    logic [IDX_W-1:0] best;
    logic             elig;

    // lane k takes the earliest eligible group not yet picked by a lower lane
    always_comb begin
        taken      = '0;
        pick_valid = '0;
        pick_idx   = '0;
        best_ok    = 1'b0;
        best       = '0;
        elig       = 1'b0;
        for (int k = 0; k < NLANE; k++) begin
            best_ok = 1'b0;
            best    = '0;
            for (int i = 0; i < NG; i++) begin
                elig = slot_valid[i] && !blocked[i] && !taken[i] && (k < int'(free_cnt));
                for (int p = 0; p < k; p++) begin
                    if (pick_valid[p] && slot_vpn[pick_idx[p]] == slot_vpn[i])
                        elig = 1'b0;
                end
                if (elig && (!best_ok || slot_bkt[i] < slot_bkt[best] ||
                             (slot_bkt[i] == slot_bkt[best] && older[i][best]))) begin
                    best    = IDX_W'(i);
                    best_ok = 1'b1;
                end
            end
            pick_valid[k] = best_ok;
            pick_idx[k]   = best;
            if (best_ok) taken[best] = 1'b1;
        end
    end
endmodule

// File: rtl/xlat_inflight_cam.sv
module xlat_inflight_cam #(
    parameter int NIFL  = 4,
    parameter int NG    = 16,
    parameter int NLANE = 2,
    parameter int VPN_W = 20,
    localparam int FC_W = $clog2(NIFL + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NG-1:0][VPN_W-1:0]      q_vpn,
    output logic [NG-1:0]                 q_hit,
    input  logic [NLANE-1:0]              alloc_valid,
    input  logic [NLANE-1:0][VPN_W-1:0]   alloc_vpn,
    input  logic                          rsp_valid,
    input  logic [VPN_W-1:0]              rsp_vpn,
    output logic [FC_W-1:0]               free_cnt
);
    typedef struct packed {
        logic [NIFL-1:0]             v;
        logic [NIFL-1:0][VPN_W-1:0]  vpn;
        logic                        pv;
        logic [VPN_W-1:0]            pvpn;
    } cam_t;

    cam_t q, d;
    logic [NIFL-1:0]  grab;
    logic             found;
    logic [NLANE-1:0] alloc_dup;

    always_comb begin
        d     = q;
        grab  = '0;
        found = 1'b0;
        // the response sampled last edge retires its entry now
        if (q.pv) begin
            for (int e = 0; e < NIFL; e++)
                if (q.v[e] && q.vpn[e] == q.pvpn) d.v[e] = 1'b0;
        end
        for (int k = 0; k < NLANE; k++) begin
            found = 1'b0;
            if (alloc_valid[k]) begin
                for (int e = 0; e < NIFL; e++) begin
                    if (!found && !q.v[e] && !grab[e]) begin
                        d.v[e]   = 1'b1;
                        d.vpn[e] = alloc_vpn[k];
                        grab[e]  = 1'b1;
                        found    = 1'b1;
                    end
                end
            end
        end
        d.pv   = rsp_valid;
        d.pvpn = rsp_vpn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        for (int i = 0; i < NG; i++) begin
            q_hit[i] = 1'b0;
            for (int e = 0; e < NIFL; e++)
                if (q.v[e] && q.vpn[e] == q_vpn[i]) q_hit[i] = 1'b1;
        end
        for (int k = 0; k < NLANE; k++) begin
            alloc_dup[k] = 1'b0;
            for (int e = 0; e < NIFL; e++)
                if (q.v[e] && q.vpn[e] == alloc_vpn[k]) alloc_dup[k] = 1'b1;
        end
        free_cnt = FC_W'(NIFL) - FC_W'($countones(q.v));
    end

    a_r12_alloc_room: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alloc_valid) <= int'(free_cnt));

    for (genvar k = 0; k < NLANE; k++) begin : g_dup
        a_r8_no_second_flight: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_valid[k] |-> !alloc_dup[k]);
    end
endmodule

// File: rtl/xlat_coalescer.sv
module xlat_coalescer
    import xlat_pkg::*;
#(
    parameter int VA_W       = XC_VA_W,
    parameter int PAGE_SHIFT = XC_PAGE_SHIFT,
    parameter int MODE_W     = XC_MODE_W,
    parameter int CNT_W      = XC_CNT_W,
    parameter int STAMP_W    = XC_STAMP_W,
    parameter int WINDOW     = XC_WINDOW,
    parameter int NGROUP     = XC_NGROUP,
    parameter int NMEMB      = XC_NMEMB,
    parameter int NLANE      = XC_NLANE,
    parameter int NIFL       = XC_NIFL,
    localparam int VPN_W = VA_W - PAGE_SHIFT,
    localparam int ACC_W = CNT_W + $clog2(NMEMB),
    localparam int MEM_W = $clog2(NMEMB + 1),
    localparam int IDX_W = $clog2(NGROUP),
    localparam int FC_W  = $clog2(NIFL + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_merge_off,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic [MODE_W-1:0]         req_mode,
    input  logic                      req_prefetch,
    input  logic [CNT_W-1:0]          req_count,
    input  logic [STAMP_W-1:0]        req_stamp,
    output logic [NLANE-1:0]          probe_valid,
    input  logic [NLANE-1:0]          probe_ready,
    output logic [NLANE*VPN_W-1:0]    probe_vpn,
    output logic [NLANE*MODE_W-1:0]   probe_mode,
    output logic [NLANE*ACC_W-1:0]    probe_count,
    output logic [NLANE*MEM_W-1:0]    probe_members,
    input  logic                      rsp_valid,
    input  logic [VPN_W-1:0]          rsp_vpn
);
    typedef struct packed {
        logic [NGROUP-1:0]               valid;
        logic [NGROUP-1:0][STAMP_W-1:0]  bkt;
        logic [NGROUP-1:0][VPN_W-1:0]    vpn;
        logic [NGROUP-1:0][MODE_W-1:0]   mode;
        logic [NGROUP-1:0][ACC_W-1:0]    cnt;
        logic [NGROUP-1:0][MEM_W-1:0]    mem;
        logic [NGROUP-1:0][NGROUP-1:0]   older;  // [i][j]: i created before j
        logic [STAMP_W-1:0]              now;
    } store_t;

    store_t q, d;

    logic [STAMP_W-1:0]              eff_stamp, req_bkt;
    logic [VPN_W-1:0]                req_vpn;
    logic                            m_hit, m_full, m_taken;
    logic [IDX_W-1:0]                m_idx;
    logic [NGROUP-1:0]               blocked;
    logic [FC_W-1:0]                 free_cnt;
    logic [NLANE-1:0]                pick_valid, acc;
    logic [NLANE-1:0][IDX_W-1:0]     pick_idx;
    logic [NLANE-1:0][VPN_W-1:0]     alloc_vpn;
    logic [NGROUP-1:0]               slot_acc;
    logic                            has_free, take;
    logic [IDX_W-1:0]                free_idx;

    assign eff_stamp = (req_stamp != '0) ? req_stamp : q.now;
    assign req_bkt   = eff_stamp / STAMP_W'(WINDOW);
    assign req_vpn   = req_vaddr[VA_W-1:PAGE_SHIFT];

    xlat_merge_match #(
        .NG(NGROUP), .BKT_W(STAMP_W), .VPN_W(VPN_W), .MODE_W(MODE_W),
        .MEM_W(MEM_W), .NMEMB(NMEMB)
    ) u_match (
        .merge_off (cfg_merge_off),
        .req_bkt   (req_bkt),
        .req_vpn   (req_vpn),
        .req_mode  (req_mode),
        .slot_valid(q.valid),
        .slot_bkt  (q.bkt),
        .slot_vpn  (q.vpn),
        .slot_mode (q.mode),
        .slot_mem  (q.mem),
        .hit       (m_hit),
        .idx       (m_idx),
        .full      (m_full)
    );

    xlat_inflight_cam #(
        .NIFL(NIFL), .NG(NGROUP), .NLANE(NLANE), .VPN_W(VPN_W)
    ) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_vpn      (q.vpn),
        .q_hit      (blocked),
        .alloc_valid(acc),
        .alloc_vpn  (alloc_vpn),
        .rsp_valid  (rsp_valid),
        .rsp_vpn    (rsp_vpn),
        .free_cnt   (free_cnt)
    );

    xlat_issue_sel #(
        .NG(NGROUP), .NLANE(NLANE), .BKT_W(STAMP_W), .VPN_W(VPN_W), .FC_W(FC_W)
    ) u_sel (
        .slot_valid(q.valid),
        .slot_bkt  (q.bkt),
        .slot_vpn  (q.vpn),
        .older     (q.older),
        .blocked   (blocked),
        .free_cnt  (free_cnt),
        .pick_valid(pick_valid),
        .pick_idx  (pick_idx)
    );

    // lane acceptance, lane outputs and free-slot search
    always_comb begin
        for (int k = 0; k < NLANE; k++) begin
            acc[k] = pick_valid[k] && probe_ready[k] && ((k == 0) || acc[(k == 0) ? 0 : k - 1]);
            alloc_vpn[k] = q.vpn[pick_idx[k]];
            probe_vpn[k*VPN_W +: VPN_W]     = q.vpn[pick_idx[k]];
            probe_mode[k*MODE_W +: MODE_W]  = q.mode[pick_idx[k]];
            probe_count[k*ACC_W +: ACC_W]   = q.cnt[pick_idx[k]];
            probe_members[k*MEM_W +: MEM_W] = q.mem[pick_idx[k]];
        end
        slot_acc = '0;
        for (int k = 0; k < NLANE; k++)
            if (acc[k]) slot_acc[pick_idx[k]] = 1'b1;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = NGROUP - 1; i >= 0; i--) begin
            if (!q.valid[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        m_taken   = m_hit && slot_acc[m_idx];
        req_ready = m_hit ? (!m_full && !m_taken) : has_free;
        take      = req_valid && req_ready;
    end
    assign probe_valid = pick_valid;

    // next state
    always_comb begin
        d     = q;
        d.now = q.now + 1'b1;
        for (int i = 0; i < NGROUP; i++)
            if (slot_acc[i]) d.valid[i] = 1'b0;
        if (take) begin
            if (m_hit) begin
                d.mem[m_idx] = q.mem[m_idx] + 1'b1;
                if (!req_prefetch)
                    d.cnt[m_idx] = q.cnt[m_idx] + ACC_W'(req_count);
            end else begin
                d.valid[free_idx] = 1'b1;
                d.bkt[free_idx]   = req_bkt;
                d.vpn[free_idx]   = req_vpn;
                d.mode[free_idx]  = req_mode;
                d.cnt[free_idx]   = ACC_W'(req_count);
                d.mem[free_idx]   = MEM_W'(1);
                for (int j = 0; j < NGROUP; j++) begin
                    d.older[free_idx][j] = 1'b0;
                    d.older[j][free_idx] = q.valid[j] && (IDX_W'(j) != free_idx);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r11_full_store: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && &q.valid && !m_hit) |-> !req_ready);

    for (genvar k = 1; k < NLANE; k++) begin : g_lane
        a_r7_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
            probe_valid[k] |-> probe_valid[k-1]);
        a_r7_lane_pages_differ: assert property (@(posedge clk) disable iff (!rst_n)
            (probe_valid[k] && probe_valid[0]) |->
            (probe_vpn[k*VPN_W +: VPN_W] != probe_vpn[VPN_W-1:0]));
    end

    for (genvar i = 0; i < NGROUP; i++) begin : g_slot
        a_r9_refused_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (q.valid[i] && !slot_acc[i]) |=> q.valid[i]);
        a_r5_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
            (q.valid[i] && !slot_acc[i]) |=> (q.cnt[i] >= $past(q.cnt[i])));
        a_r11_member_cap: assert property (@(posedge clk) disable iff (!rst_n)
            q.valid[i] |-> (q.mem[i] <= MEM_W'(NMEMB)));
    end
endmodule

// File: tb/xlat_coalescer_tb.sv
module xlat_coalescer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_merge_off = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_mode = '0;
    logic        req_prefetch = 1'b0;
    logic [7:0]  req_count = '0;
    logic [15:0] req_stamp = '0;
    logic [1:0]  probe_valid;
    logic [1:0]  probe_ready = '0;
    logic [39:0] probe_vpn;
    logic [3:0]  probe_mode;
    logic [21:0] probe_count;
    logic [7:0]  probe_members;
    logic        rsp_valid = 1'b0;
    logic [19:0] rsp_vpn = '0;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    xlat_coalescer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_merge_off(cfg_merge_off),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_mode(req_mode), .req_prefetch(req_prefetch), .req_count(req_count),
        .req_stamp(req_stamp), .probe_valid(probe_valid), .probe_ready(probe_ready),
        .probe_vpn(probe_vpn), .probe_mode(probe_mode), .probe_count(probe_count),
        .probe_members(probe_members), .rsp_valid(rsp_valid), .rsp_vpn(rsp_vpn)
    );

    typedef struct packed {
        logic [7:0]  av; logic [1:0] am; logic [15:0] as; logic [7:0] ac; logic ap;
        logic [7:0]  bv; logic [1:0] bm; logic [15:0] bs; logic [7:0] bc; logic bp;
        logic [1:0]  ev; logic [7:0] e0v; logic [10:0] e0c; logic [3:0] e0m; logic [7:0] e1v;
    } vec_t;

    // two requests, then the lanes expected with all probes held back
    localparam vec_t VEC [7] = '{
        '{8'd5, 2'd0, 16'd16, 8'd3, 1'b0, 8'd5, 2'd0, 16'd17, 8'd4, 1'b0, 2'b01, 8'd5, 11'd7, 4'd2, 8'd0},
        '{8'd5, 2'd0, 16'd16, 8'd3, 1'b0, 8'd5, 2'd0, 16'd17, 8'd4, 1'b1, 2'b01, 8'd5, 11'd3, 4'd2, 8'd0},
        '{8'd5, 2'd0, 16'd16, 8'd3, 1'b0, 8'd5, 2'd1, 16'd17, 8'd4, 1'b0, 2'b01, 8'd5, 11'd3, 4'd1, 8'd0},
        '{8'd5, 2'd0, 16'd16, 8'd3, 1'b0, 8'd5, 2'd0, 16'd24, 8'd4, 1'b0, 2'b01, 8'd5, 11'd3, 4'd1, 8'd0},
        '{8'd5, 2'd0, 16'd16, 8'd3, 1'b0, 8'd6, 2'd0, 16'd17, 8'd4, 1'b0, 2'b11, 8'd5, 11'd3, 4'd1, 8'd6},
        '{8'd5, 2'd0, 16'd40, 8'd3, 1'b0, 8'd6, 2'd0, 16'd9,  8'd4, 1'b0, 2'b11, 8'd6, 11'd4, 4'd1, 8'd5},
        '{8'd5, 2'd0, 16'd16, 8'd3, 1'b1, 8'd5, 2'd0, 16'd17, 8'd4, 1'b0, 2'b01, 8'd5, 11'd7, 4'd2, 8'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [19:0] vpn, input logic [1:0] mode, input logic [15:0] stamp,
                        input logic [7:0] cnt, input logic pf);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {vpn, 12'h0a4}; req_mode = mode;
        req_stamp = stamp; req_count = cnt; req_prefetch = pf;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic respond(input logic [19:0] vpn);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_vpn = vpn;
        @(posedge clk);
        #1 rsp_valid = 1'b0;
    endtask

    task automatic drain(input logic [19:0] a, input logic [19:0] b);
        probe_ready = 2'b11;
        repeat (3) begin
            repeat (4) @(posedge clk);
            respond(a);
            respond(b);
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        probe_ready = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int acc_total;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 probe_valid after reset", 32'(probe_valid), 0);
        check("R1 req_ready after reset", 32'(req_ready), 1);

        // table walk: merge keys, counts and lane order (R3 R4 R5 R6)
        foreach (VEC[n]) begin
            send(20'(VEC[n].av), VEC[n].am, VEC[n].as, VEC[n].ac, VEC[n].ap);
            send(20'(VEC[n].bv), VEC[n].bm, VEC[n].bs, VEC[n].bc, VEC[n].bp);
            @(negedge clk);
            check($sformatf("R3 R4 vec%0d lanes", n), 32'(probe_valid), 32'(VEC[n].ev));
            check($sformatf("R6 vec%0d lane0 page", n), 32'(probe_vpn[19:0]), 32'(VEC[n].e0v));
            check($sformatf("R5 vec%0d lane0 count", n), 32'(probe_count[10:0]), 32'(VEC[n].e0c));
            check($sformatf("R3 vec%0d lane0 members", n), 32'(probe_members[3:0]), 32'(VEC[n].e0m));
            if (VEC[n].ev[1])
                check($sformatf("R6 vec%0d lane1 page", n), 32'(probe_vpn[39:20]), 32'(VEC[n].e1v));
            drain(20'(VEC[n].av), 20'(VEC[n].bv));
        end

        // R2: unstamped request takes the small cycle counter, so its bucket is older
        send(20'd40, 2'd0, 16'd60000, 8'd1, 1'b0);
        send(20'd41, 2'd0, 16'd0, 8'd1, 1'b0);
        @(negedge clk);
        check("R2 unstamped first lane0", 32'(probe_vpn[19:0]), 41);
        check("R2 stamped second lane1", 32'(probe_vpn[39:20]), 40);
        drain(20'd40, 20'd41);

        // R8: page in flight blocks a later group until two edges after the response
        send(20'd9, 2'd0, 16'd8, 8'd1, 1'b0);
        @(negedge clk);
        check("R8 first group offered", 32'(probe_valid), 1);
        probe_ready = 2'b01;
        @(posedge clk);
        send(20'd9, 2'd0, 16'd16, 8'd1, 1'b0);
        @(negedge clk);
        check("R8 blocked while in flight", 32'(probe_valid), 0);
        rsp_valid = 1'b1; rsp_vpn = 20'd9;
        @(posedge clk);
        #1 rsp_valid = 1'b0;
        @(negedge clk);
        check("R8 still blocked one edge after response", 32'(probe_valid), 0);
        @(negedge clk);
        check("R8 offered after release", 32'(probe_valid), 1);
        check("R8 released page", 32'(probe_vpn[19:0]), 9);
        drain(20'd9, 20'd9);

        // R9: refusal holds lanes; lane1 cannot go without lane0
        send(20'd1, 2'd0, 16'd16, 8'd1, 1'b0);
        send(20'd2, 2'd0, 16'd16, 8'd1, 1'b0);
        @(negedge clk);
        check("R9 both offered", 32'(probe_valid), 3);
        probe_ready = 2'b10;
        @(negedge clk);
        check("R9 nothing taken when lane0 refused", 32'(probe_valid), 3);
        check("R9 lane0 unchanged", 32'(probe_vpn[19:0]), 1);
        probe_ready = 2'b01;
        @(negedge clk);
        check("R9 only lane0 taken", 32'(probe_valid), 1);
        check("R9 remaining group moves to lane0", 32'(probe_vpn[19:0]), 2);
        drain(20'd1, 20'd2);

        // R10: merging disabled
        cfg_merge_off = 1'b1;
        send(20'd3, 2'd0, 16'd16, 8'd5, 1'b0);
        send(20'd3, 2'd0, 16'd16, 8'd5, 1'b0);
        @(negedge clk);
        check("R10 single member", 32'(probe_members[3:0]), 1);
        check("R10 own count", 32'(probe_count[10:0]), 5);
        probe_ready = 2'b01;
        @(posedge clk);
        respond(20'd3);
        @(negedge clk);
        @(negedge clk);
        check("R10 second group offered", 32'(probe_valid), 1);
        check("R10 second group single member", 32'(probe_members[3:0]), 1);
        drain(20'd3, 20'd3);
        cfg_merge_off = 1'b0;

        // R11: capacity of groups and members
        for (int v = 16; v < 32; v++) send(20'(v), 2'd0, 16'd16, 8'd1, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {20'd50, 12'h0}; req_mode = 2'd0; req_stamp = 16'd16;
        #1 check("R11 no slot for new page", 32'(req_ready), 0);
        req_vaddr = {20'd16, 12'h0};
        #1 check("R11 merge allowed when slots used", 32'(req_ready), 1);
        req_valid = 1'b0;
        for (int m = 0; m < 7; m++) send(20'd16, 2'd0, 16'd16, 8'd1, 1'b0);
        @(negedge clk);
        check("R11 group at member limit", 32'(probe_members[3:0]), 8);
        req_valid = 1'b1; req_vaddr = {20'd16, 12'h0};
        #1 check("R11 ready low at member limit", 32'(req_ready), 0);
        req_valid = 1'b0;

        // R12 and R7: only NIFL pages outstanding, two lanes per cycle
        probe_ready = 2'b11;
        #1 check("R7 two lanes offered", 32'(probe_valid), 3);
        acc_total = 0;
        repeat (6) begin
            acc_total += $countones(probe_valid);
            @(negedge clk);
        end
        check("R12 accepted probes bounded", 32'(acc_total), 4);
        check("R12 no offer with table full", 32'(probe_valid), 0);
        for (int v = 16; v < 32; v++) begin
            respond(20'(v));
            repeat (3) @(posedge clk);
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R12 all drained", 32'(probe_valid), 0);
        check("R11 ready after drain", 32'(req_ready), 1);
        probe_ready = 2'b00;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule